// File: doc/BRIEF.md
# Interlaced Raster Timing Generator

This block produces the pixel and line counters, horizontal sync, vertical sync, composite sync and data-enable for a display raster. It handles both progressive and interlaced modes. Coordinates count from the top-left pixel of the visible area. Pixel 0 of line 0 is the first visible pixel. The blanking intervals and sync pulses follow the visible region on each line and in each field.

The block holds two per-field parameter sets: line total, field line count, the first and last VSYNC lines, and the pixel at which VSYNC changes within a line. This lets an interlaced raster alternate between fields of different lengths. A typical case is an odd field one line longer than the even field, with its VSYNC edges moved to mid-line. In progressive mode the counters use only field set 0 and no field pulses appear. In interlaced mode the field sets alternate and a one-cycle pulse marks the first pixel of each field.

Configuration writes land in shadow registers. Every shadow value moves into the working set together, at the first pixel of the vertical blanking that follows the last visible line. A field therefore never changes its timing mid-way through its visible lines.

Top module: `raster_timing_gen`

## Requirements
- R1: While reset is asserted and right after it, the raster sits at pixel 0, line 0, field 0. Data-enable is high and every sync output is low. The field pulse is low. The built-in mode is progressive: 8 of 16 pixels visible, 4 of 8 lines visible, HSYNC on pixels 10 to 11, VSYNC from line 5 pixel 10 to line 6 pixel 10, no inversion.
- R2: The pixel counter steps by one each clock. After pixel (line total - 1) of the current field's set it returns to 0 and the line counter advances. After line (field line count - 1) the line counter returns to 0.
- R3: Data-enable is high exactly when the pixel is below the visible width and the current field has not yet passed its last visible line (line below the visible height).
- R4: Before inversion, HSYNC is high for pixels p with start <= p < stop on every line.
- R5: Before inversion, VSYNC is high from (first line, VSYNC pixel) inclusive to (last line, VSYNC pixel) exclusive in raster order. These values come from the current field's set.
- R6: In progressive mode (mode bit 0 clear) the field output stays 0 after the working mode reaches progressive and one field has wrapped. The field pulse never fires, and field set 1 has no effect.
- R7: In interlaced mode (mode bit 0 set) the field number changes at each field wrap, alternating between 0 and 1. The field pulse is high for exactly one clock, at pixel 0 of line 0 of each field.
- R8: Register map, with address bit 3 selecting the field set for the per-field registers. Address 0 holds visible height in [31:16] and visible width in [15:0]. Address 1 holds the HSYNC stop in [31:16] and start in [15:0]. Address 2 holds the mode: bit 0 interlace, bit 1 invert HSYNC, bit 2 invert VSYNC, bit 3 invert composite sync. Field addresses 4/12 hold the line count in [31:16] and the line total in [15:0]. Field addresses 5/13 hold the VSYNC last line in [31:16] and first line in [15:0]. Field addresses 6/14 hold the VSYNC pixel in [15:0]. Writes to any other address (3, 7, 8 to 11, 15) have no effect.
- R9: A write changes no output until the first pixel of line (visible height) in the current field. From that pixel on, all shadow values govern together.
- R10: Each mode invert bit makes its output active low. Composite sync is HSYNC OR VSYNC before its own inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| h_pos_o | output | CNT_W | Current pixel within the line |
| v_pos_o | output | CNT_W | Current line within the field |
| de_o | output | 1 | Data-enable |
| hsync_o | output | 1 | Horizontal sync after polarity |
| vsync_o | output | 1 | Vertical sync after polarity |
| csync_o | output | 1 | Composite sync after polarity |
| field_id_o | output | 1 | Current field number |
| field_start_o | output | 1 | One-clock pulse at the first pixel of an interlaced field |

## Verification
A reference raster is computed arithmetically beside the design and compared every clock. The comparison first runs the built-in mode, then a progressive mode in which field set 1 holds conflicting values. Next, the VSYNC pixel and HSYNC window are swept across every pixel of a 20-pixel line, which separates inclusive from exclusive edge handling at each boundary. An interlaced pair of 9-line and 8-line fields follows, with VSYNC at different pixels, to show that the field parameters alternate. Writes to unmapped addresses, all-inverted polarity and a return to progressive mode separate decode errors, polarity errors and a field number that fails to return to 0. Writes issued in mid-field show whether the shadow registers take effect early or late.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

   localparam int HALF_W     = 16;
   localparam int NUM_FIELDS = 2;
   localparam int FLD_W      = $clog2(NUM_FIELDS);
   localparam int SEL_W      = 3;
   localparam int ADDR_W     = SEL_W + FLD_W;

   typedef logic [HALF_W-1:0] coord_t;

   typedef struct packed {
      coord_t htot;
      coord_t vtot;
      coord_t vs_first;
      coord_t vs_last;
      coord_t vs_hpos;
   } field_cfg_t;

   typedef struct packed {
      coord_t hact;
      coord_t vact;
      coord_t hs_on;
      coord_t hs_off;
      logic   interlace;
      logic   inv_h;
      logic   inv_v;
      logic   inv_c;
   } line_cfg_t;

   localparam logic [SEL_W-1:0] SEL_ACTIVE = 3'd0;
   localparam logic [SEL_W-1:0] SEL_HSYNC  = 3'd1;
   localparam logic [SEL_W-1:0] SEL_MODE   = 3'd2;
   localparam logic [SEL_W-1:0] SEL_TOTAL  = 3'd4;
   localparam logic [SEL_W-1:0] SEL_VSLINE = 3'd5;
   localparam logic [SEL_W-1:0] SEL_VSPIX  = 3'd6;

   function automatic field_cfg_t field_boot();
      field_cfg_t f;
      f.htot     = 16'd16;
      f.vtot     = 16'd8;
      f.vs_first = 16'd5;
      f.vs_last  = 16'd6;
      f.vs_hpos  = 16'd10;
      return f;
   endfunction

   function automatic line_cfg_t line_boot();
      line_cfg_t l;
      l.hact      = 16'd8;
      l.vact      = 16'd4;
      l.hs_on     = 16'd10;
      l.hs_off    = 16'd12;
      l.interlace = 1'b0;
      l.inv_h     = 1'b0;
      l.inv_v     = 1'b0;
      l.inv_c     = 1'b0;
      return l;
   endfunction

endpackage

// File: rtl/rtg_shadow_bank.sv
module rtg_shadow_bank
   import rtg_pkg::*;
(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [31:0]                   wr_data,
   input  logic                          load,
   output line_cfg_t                     line_act,
   output field_cfg_t [NUM_FIELDS-1:0]   fld_act
);

   logic [SEL_W-1:0] sel;
   logic [FLD_W-1:0] bank;
   coord_t           hi_half;
   coord_t           lo_half;
   line_cfg_t        line_sh;

   assign sel     = wr_addr[SEL_W-1:0];
   assign bank    = wr_addr[ADDR_W-1:SEL_W];
   assign hi_half = wr_data[31:16];
   assign lo_half = wr_data[15:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_sh <= line_boot();
      end else if (wr_en && (bank == '0)) begin
         case (sel)
            SEL_ACTIVE: begin
               line_sh.vact <= hi_half;
               line_sh.hact <= lo_half;
            end
            SEL_HSYNC: begin
               line_sh.hs_off <= hi_half;
               line_sh.hs_on  <= lo_half;
            end
            SEL_MODE: begin
               line_sh.interlace <= wr_data[0];
               line_sh.inv_h     <= wr_data[1];
               line_sh.inv_v     <= wr_data[2];
               line_sh.inv_c     <= wr_data[3];
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_act <= line_boot();
      end else if (load) begin
         line_act <= line_sh;
      end
   end

   generate
      for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_bank
         field_cfg_t sh;
         field_cfg_t act;
         logic       hit;

         assign hit = wr_en && (bank == FLD_W'(f));

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               sh <= field_boot();
            end else if (hit) begin
               case (sel)
                  SEL_TOTAL: begin
                     sh.vtot <= hi_half;
                     sh.htot <= lo_half;
                  end
                  SEL_VSLINE: begin
                     sh.vs_last  <= hi_half;
                     sh.vs_first <= lo_half;
                  end
                  SEL_VSPIX: begin
                     sh.vs_hpos <= lo_half;
                  end
                  default: ;
               endcase
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act <= field_boot();
            end else if (load) begin
               act <= sh;
            end
         end

         assign fld_act[f] = act;
      end
   endgenerate

endmodule

// File: rtl/rtg_raster_count.sv
module rtg_raster_count
   import rtg_pkg::*;
#(
   parameter int CNT_W = 12
)(
   input  logic             clk,
   input  logic             rst_n,
   input  line_cfg_t        line_act,
   input  field_cfg_t       cur_fld,
   output logic [CNT_W-1:0] h_cnt,
   output logic [CNT_W-1:0] v_cnt,
   output logic [FLD_W-1:0] field_q,
   output logic             vblank_q,
   output logic             load_o
);

   localparam logic [FLD_W-1:0] LAST_FIELD = FLD_W'(NUM_FIELDS - 1);

   coord_t           h_nxt;
   coord_t           v_nxt;
   logic             h_end;
   logic             v_end;
   logic [FLD_W-1:0] field_adv;

   assign h_nxt  = coord_t'(h_cnt) + 16'd1;
   assign v_nxt  = coord_t'(v_cnt) + 16'd1;
   assign h_end  = (h_nxt >= cur_fld.htot);
   assign v_end  = (v_nxt >= cur_fld.vtot);
   assign load_o = h_end && (v_nxt == line_act.vact);

   always_comb begin
      if (!line_act.interlace || (field_q == LAST_FIELD)) begin
         field_adv = '0;
      end else begin
         field_adv = field_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         h_cnt    <= '0;
         v_cnt    <= '0;
         field_q  <= '0;
         vblank_q <= 1'b0;
      end else if (h_end) begin
         h_cnt <= '0;
         if (v_end) begin
            v_cnt    <= '0;
            vblank_q <= 1'b0;
            field_q  <= field_adv;
         end else begin
            v_cnt <= v_cnt + 1'b1;
            if (load_o) begin
               vblank_q <= 1'b1;
            end
         end
      end else begin
         h_cnt <= h_cnt + 1'b1;
      end
   end

endmodule

// File: rtl/rtg_sync_decode.sv
module rtg_sync_decode
   import rtg_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter bit CSYNC_XOR = 1'b0
)(
   input  logic [CNT_W-1:0] h_cnt,
   input  logic [CNT_W-1:0] v_cnt,
   input  logic             vblank,
   input  line_cfg_t        line_act,
   input  field_cfg_t       cur_fld,
   output logic             de,
   output logic             hsync,
   output logic             vsync,
   output logic             csync,
   output logic             field_start
);

   coord_t hx;
   coord_t vx;
   logic   hs_raw;
   logic   vs_raw;
   logic   past_start;
   logic   before_stop;
   logic   sync_mix;

   assign hx = coord_t'(h_cnt);
   assign vx = coord_t'(v_cnt);

   assign de     = !vblank && (hx < line_act.hact);
   assign hs_raw = (hx >= line_act.hs_on) && (hx < line_act.hs_off);

   assign past_start  = (vx > cur_fld.vs_first) ||
                        ((vx == cur_fld.vs_first) && (hx >= cur_fld.vs_hpos));
   assign before_stop = (vx < cur_fld.vs_last) ||
                        ((vx == cur_fld.vs_last) && (hx < cur_fld.vs_hpos));
   assign vs_raw      = past_start && before_stop;

   generate
      if (CSYNC_XOR) begin : g_csync_xor
         assign sync_mix = hs_raw ^ vs_raw;
      end else begin : g_csync_or
         assign sync_mix = hs_raw | vs_raw;
      end
   endgenerate

   assign hsync       = hs_raw ^ line_act.inv_h;
   assign vsync       = vs_raw ^ line_act.inv_v;
   assign csync       = sync_mix ^ line_act.inv_c;
   assign field_start = line_act.interlace && (hx == '0) && (vx == '0);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
   import rtg_pkg::*;
#(
   parameter int CNT_W     = 12,
   parameter bit CSYNC_XOR = 1'b0
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   output logic [CNT_W-1:0]  h_pos_o,
   output logic [CNT_W-1:0]  v_pos_o,
   output logic              de_o,
   output logic              hsync_o,
   output logic              vsync_o,
   output logic              csync_o,
   output logic              field_id_o,
   output logic              field_start_o
);

   generate
      if (CNT_W < 4 || CNT_W >= HALF_W) begin : g_bad_cnt_w
         $error("raster_timing_gen: CNT_W must lie in 4..15");
      end
      if (ADDR_W != 4 || FLD_W != 1) begin : g_bad_map
         $error("raster_timing_gen: register map expects two field sets");
      end
   endgenerate

   line_cfg_t                   line_act;
   field_cfg_t [NUM_FIELDS-1:0] fld_act;
   field_cfg_t                  cur_fld;
   logic [CNT_W-1:0]            h_cnt;
   logic [CNT_W-1:0]            v_cnt;
   logic [FLD_W-1:0]            field_q;
   logic                        vblank_q;
   logic                        load;

   rtg_shadow_bank u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (cfg_we),
      .wr_addr  (cfg_addr),
      .wr_data  (cfg_wdata),
      .load     (load),
      .line_act (line_act),
      .fld_act  (fld_act)
   );

   assign cur_fld = fld_act[field_q];

   rtg_raster_count #(.CNT_W(CNT_W)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_act (line_act),
      .cur_fld  (cur_fld),
      .h_cnt    (h_cnt),
      .v_cnt    (v_cnt),
      .field_q  (field_q),
      .vblank_q (vblank_q),
      .load_o   (load)
   );

   rtg_sync_decode #(.CNT_W(CNT_W), .CSYNC_XOR(CSYNC_XOR)) u_sync (
      .h_cnt       (h_cnt),
      .v_cnt       (v_cnt),
      .vblank      (vblank_q),
      .line_act    (line_act),
      .cur_fld     (cur_fld),
      .de          (de_o),
      .hsync       (hsync_o),
      .vsync       (vsync_o),
      .csync       (csync_o),
      .field_start (field_start_o)
   );

   assign h_pos_o    = h_cnt;
   assign v_pos_o    = v_cnt;
   assign field_id_o = field_q[0];

endmodule

// File: rtl/raster_timing_chk.sv
module raster_timing_chk #(
   parameter int CNT_W = 12
)(
   input logic             clk,
   input logic             rst_n,
   input logic [CNT_W-1:0] h_pos,
   input logic [CNT_W-1:0] v_pos,
   input logic             field_id,
   input logic             field_start,
   input logic             vblank,
   input logic             de
);

   assert_h_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (h_pos != '0) |-> (h_pos == $past(h_pos) + 1'b1));

   assert_v_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (h_pos != '0) |-> $stable(v_pos));

   assert_pulse_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
      field_start |-> ((h_pos == '0) && (v_pos == '0)));

   assert_field_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (field_id != $past(field_id)) |-> ((h_pos == '0) && (v_pos == '0)));

   assert_blank_line_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vblank) |-> ((h_pos == '0) && !de));

   assert_origin_visible_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((h_pos == '0) && (v_pos == '0)) |-> !vblank);

endmodule

bind raster_timing_gen raster_timing_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .h_pos       (h_pos_o),
   .v_pos       (v_pos_o),
   .field_id    (field_id_o),
   .field_start (field_start_o),
   .vblank      (vblank_q),
   .de          (de_o)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;

   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cfg_we = 1'b0;
   logic [3:0]    cfg_addr = '0;
   logic [31:0]   cfg_wdata = '0;
   logic [CW-1:0] h_pos_o;
   logic [CW-1:0] v_pos_o;
   logic          de_o, hsync_o, vsync_o, csync_o, field_id_o, field_start_o;

   int total = 0;
   int bad = 0;
   bit running = 1'b0;
   bit finished = 1'b0;

   always #10 clk = ~clk;

   raster_timing_gen #(.CNT_W(CW)) i_raster_timing_gen (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
      .cfg_wdata(cfg_wdata), .h_pos_o(h_pos_o), .v_pos_o(v_pos_o),
      .de_o(de_o), .hsync_o(hsync_o), .vsync_o(vsync_o), .csync_o(csync_o),
      .field_id_o(field_id_o), .field_start_o(field_start_o)
   );

   // reference raster, shadow (s_) and working (a_) parameter sets
   int s_hact, s_vact, s_hson, s_hsoff, s_il, s_ih, s_iv, s_ic;
   int a_hact, a_vact, a_hson, a_hsoff, a_il, a_ih, a_iv, a_ic;
   int s_htot[2], s_vtot[2], s_vsf[2], s_vsl[2], s_vsp[2];
   int a_htot[2], a_vtot[2], a_vsf[2], a_vsl[2], a_vsp[2];
   int eh, ev, ef, eb;
   bit pend, ign;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d (pixel %0d line %0d)", tag, what, act, exp, eh, ev);
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s_hact <= 8;  s_vact <= 4;  s_hson <= 10; s_hsoff <= 12;
         s_il <= 0; s_ih <= 0; s_iv <= 0; s_ic <= 0;
         a_hact <= 8;  a_vact <= 4;  a_hson <= 10; a_hsoff <= 12;
         a_il <= 0; a_ih <= 0; a_iv <= 0; a_ic <= 0;
         for (int f = 0; f < 2; f++) begin
            s_htot[f] <= 16; s_vtot[f] <= 8; s_vsf[f] <= 5; s_vsl[f] <= 6; s_vsp[f] <= 10;
            a_htot[f] <= 16; a_vtot[f] <= 8; a_vsf[f] <= 5; a_vsl[f] <= 6; a_vsp[f] <= 10;
         end
         eh <= 0; ev <= 0; ef <= 0; eb <= 0; pend <= 0; ign <= 0;
      end else begin
         automatic bit he = (eh + 1 >= a_htot[ef]);
         automatic bit ld = he && (ev + 1 == a_vact);
         automatic int fb = int'(cfg_addr[3]);
         automatic int hi = int'(cfg_wdata[31:16]);
         automatic int lo = int'(cfg_wdata[15:0]);
         automatic bit valid;
         if (he) begin
            eh <= 0;
            if (ev + 1 >= a_vtot[ef]) begin
               ev <= 0; eb <= 0;
               ef <= (a_il != 0) ? 1 - ef : 0;
            end else begin
               ev <= ev + 1;
               if (ld) eb <= 1;
            end
         end else begin
            eh <= eh + 1;
         end
         if (ld) begin
            a_hact <= s_hact; a_vact <= s_vact; a_hson <= s_hson; a_hsoff <= s_hsoff;
            a_il <= s_il; a_ih <= s_ih; a_iv <= s_iv; a_ic <= s_ic;
            a_htot <= s_htot; a_vtot <= s_vtot; a_vsf <= s_vsf; a_vsl <= s_vsl; a_vsp <= s_vsp;
            pend <= 0;
         end
         valid = 0;
         if (cfg_we) begin
            if (fb == 0) begin
               case (cfg_addr[2:0])
                  3'd0: begin s_vact <= hi; s_hact <= lo; valid = 1; end
                  3'd1: begin s_hsoff <= hi; s_hson <= lo; valid = 1; end
                  3'd2: begin
                     s_il <= int'(cfg_wdata[0]); s_ih <= int'(cfg_wdata[1]);
                     s_iv <= int'(cfg_wdata[2]); s_ic <= int'(cfg_wdata[3]);
                     valid = 1;
                  end
                  default: ;
               endcase
            end
            case (cfg_addr[2:0])
               3'd4: begin s_vtot[fb] <= hi; s_htot[fb] <= lo; valid = 1; end
               3'd5: begin s_vsl[fb] <= hi; s_vsf[fb] <= lo; valid = 1; end
               3'd6: begin s_vsp[fb] <= lo; valid = 1; end
               default: ;
            endcase
            if (valid) begin pend <= 1; ign <= 0; end
            else ign <= 1;
         end
      end
   end

   always @(negedge clk) begin
      if (running && rst_n) begin
         automatic int f = ef;
         automatic bit x_de = (eb == 0) && (eh < a_hact);
         automatic bit x_hs = (eh >= a_hson) && (eh < a_hsoff);
         automatic bit aft = (ev > a_vsf[f]) || ((ev == a_vsf[f]) && (eh >= a_vsp[f]));
         automatic bit bef = (ev < a_vsl[f]) || ((ev == a_vsl[f]) && (eh < a_vsp[f]));
         automatic bit x_vs = aft && bef;
         automatic bit x_fs = (a_il != 0) && (eh == 0) && (ev == 0);
         automatic string fm = (a_il != 0) ? "R7" : "R6";
         automatic string pre = pend ? "R9" : (ign ? "R8" : "");
         chk(pend || ign ? pre : "R2", "h_pos", int'(h_pos_o), eh);
         chk(pend || ign ? pre : "R2", "v_pos", int'(v_pos_o), ev);
         chk(pend || ign ? pre : "R3", "de", int'(de_o), int'(x_de));
         chk(pend || ign ? pre : "R4", "hsync", int'(hsync_o), int'(x_hs ^ (a_ih != 0)));
         chk(pend || ign ? pre : "R5", "vsync", int'(vsync_o), int'(x_vs ^ (a_iv != 0)));
         chk(pend || ign ? pre : "R10", "csync", int'(csync_o), int'((x_hs | x_vs) ^ (a_ic != 0)));
         chk(pend || ign ? pre : fm, "field_id", int'(field_id_o), ef);
         chk(pend || ign ? pre : fm, "field_start", int'(field_start_o), int'(x_fs));
      end
   end

   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "h_pos", int'(h_pos_o), 0);
      chk("R1", "v_pos", int'(v_pos_o), 0);
      chk("R1", "de", int'(de_o), 1);
      chk("R1", "hsync", int'(hsync_o), 0);
      chk("R1", "vsync", int'(vsync_o), 0);
      chk("R1", "csync", int'(csync_o), 0);
      chk("R1", "field_id", int'(field_id_o), 0);
      chk("R1", "field_start", int'(field_start_o), 0);
      rst_n = 1'b1;
      running = 1'b1;
      run(300);                               // built-in mode, two frames (R1, R2)
      // progressive mode; field set 1 gets conflicting values (R6, R8, R9)
      wr(4'd0,  {16'd5,  16'd12});
      wr(4'd1,  {16'd16, 16'd14});
      wr(4'd2,  32'd0);
      wr(4'd4,  {16'd8,  16'd20});
      wr(4'd5,  {16'd7,  16'd6});
      wr(4'd6,  {16'd0,  16'd14});
      wr(4'd12, {16'd3,  16'd7});
      wr(4'd13, {16'd1,  16'd0});
      wr(4'd14, {16'd0,  16'd2});
      run(400);
      // unmapped addresses, R8
      wr(4'd3,  32'hFFFF_FFFF);
      wr(4'd7,  32'hFFFF_FFFF);
      wr(4'd8,  32'h0001_0001);
      wr(4'd10, 32'h0000_000F);
      wr(4'd11, 32'h0000_0003);
      wr(4'd15, 32'hFFFF_FFFF);
      run(400);
      // sweep VSYNC pixel and HSYNC window over the whole line (R4, R5)
      for (int k = 0; k < 20; k++) begin
         wr(4'd6, 32'(k));
         wr(4'd1, {16'(k + 3), 16'(k)});
         run(330);
      end
      // interlaced: 9-line odd field, 8-line even field (R7)
      wr(4'd1,  {16'd16, 16'd14});
      wr(4'd4,  {16'd9,  16'd20});
      wr(4'd5,  {16'd8,  16'd7});
      wr(4'd6,  {16'd0,  16'd4});
      wr(4'd12, {16'd8,  16'd20});
      wr(4'd13, {16'd7,  16'd6});
      wr(4'd14, {16'd0,  16'd14});
      wr(4'd2,  32'd1);
      run(1100);
      // all polarities inverted (R10)
      wr(4'd2, 32'h0000_000F);
      run(400);
      // back to progressive, field must return to 0 (R6)
      wr(4'd2, 32'd0);
      run(500);
      running = 1'b0;
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog act=running exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule